// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is a single capture channel of a general-purpose timer. One of two input pins is selected and passed through a two-flop synchronizer. A digital noise filter follows. It accepts a new level only after that level has been seen on a run of consecutive samples. An edge detector then picks out either rising or falling transitions, and an event divider lets only every 1st, 2nd, 4th or 8th such edge through.

Each event that passes, or a software trigger, copies the free-running counter value into the capture register and sets the capture flag. If an event arrives while the flag is still set, the register is overwritten with the newer count and a separate overcapture flag is raised. The flag, together with an interrupt enable and a DMA enable, drives the interrupt and DMA request outputs. The surrounding timer supplies the counter value and produces the read and clear strobes from its register interface.

Top module: `cap_channel`

## Requirements
- R1: On a capture event, the value of `cnt_in` in that cycle appears on `cap_val` after the next clock edge, and `cap_flag` becomes 1.
- R2: A capture event while `cap_flag` is 1 overwrites `cap_val` with the new count and sets `ovr_flag` to 1.
- R3: With `edge_neg` = 0, rising transitions of the filtered input are the qualifying edges. With `edge_neg` = 1, falling transitions are.
- R4: With `src_sel` = 0 the channel watches `pin_own`. With `src_sel` = 1 it watches `pin_alt`.
- R5: With filter setting k on `flt_cfg`, a new input level is accepted only after it has been held for N = 2^min(k,4) consecutive synchronized samples (1, 2, 4, 8, 16). A pulse shorter than N samples produces no edge.
- R6: `div_cfg` values 0, 1, 2 and 3 capture on every 1st, 2nd, 4th and 8th qualifying edge. The edge count returns to zero whenever `chan_en` is 0.
- R7: While `chan_en` is 0, no capture takes place, from the pin or from `sw_trig`.
- R8: A one-cycle `sw_trig` with `chan_en` = 1 causes a capture at once, regardless of the pin and the divider.
- R9: `rd_cap` clears `cap_flag` and `ovr_clr` clears `ovr_flag` at the next edge. A capture in the same cycle takes precedence.
- R10: `irq_req` is 1 exactly when `cap_flag` and `irq_en` are both 1. `dma_req` is 1 exactly when `cap_flag` and `dma_en` are both 1.
- R11: After reset, `cap_val` is 0 and `cap_flag`, `ovr_flag`, `irq_req` and `dma_req` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_own | input | 1 | Channel's own input pin |
| pin_alt | input | 1 | Neighbouring channel's pin |
| src_sel | input | 1 | Input source: 0 own pin, 1 neighbour pin |
| flt_cfg | input | 4 | Filter setting |
| edge_neg | input | 1 | Edge polarity: 0 rising, 1 falling |
| div_cfg | input | 2 | Event divider: 1, 2, 4 or 8 edges |
| chan_en | input | 1 | Channel enable |
| sw_trig | input | 1 | Software capture trigger |
| irq_en | input | 1 | Interrupt request enable |
| dma_en | input | 1 | DMA request enable |
| rd_cap | input | 1 | Capture register read strobe, clears `cap_flag` |
| ovr_clr | input | 1 | Clears `ovr_flag` |
| cnt_in | input | CW | Timer counter value |
| cap_val | output | CW | Captured counter value |
| cap_flag | output | 1 | Capture pending flag |
| ovr_flag | output | 1 | Overcapture flag |
| irq_req | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The hardest situation to reach from the ports is a pin pulse that the filter must reject. That pulse must then be told apart from one that arrives late. The bench drives pulses whose width is a few cycles short of the filter length. It then waits well past the longest path from pin to flag before checking that nothing was captured, and follows with a pulse just long enough to be accepted.

Divider behaviour across a disable is the next hardest case. The bench leaves the edge count part way through, drops `chan_en` for a cycle, and shows that the next edge does not complete the interrupted group. Polarity is told apart by sampling the flag between the rising and the falling transition of each pulse.

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_own,
  input  logic          pin_alt,
  input  logic          src_sel,
  input  logic [3:0]    flt_cfg,
  input  logic          edge_neg,
  input  logic [1:0]    div_cfg,
  input  logic          chan_en,
  input  logic          sw_trig,
  input  logic          irq_en,
  input  logic          dma_en,
  input  logic          rd_cap,
  input  logic          ovr_clr,
  input  logic [CW-1:0] cnt_in,
  output logic [CW-1:0] cap_val,
  output logic          cap_flag,
  output logic          ovr_flag,
  output logic          irq_req,
  output logic          dma_req
);
  localparam int RUNW = 5;

  logic [1:0]      sync;
  logic            lvl, lvl_q;
  logic [RUNW-1:0] run, need;
  logic [2:0]      evc, lim;
  logic            hit, div_hit, fire;

  wire raw = src_sel ? pin_alt : pin_own;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[0], raw};

  always_comb begin
    if (flt_cfg >= 4'd4) need = RUNW'(16);
    else                 need = RUNW'(1) << flt_cfg[1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl <= 1'b0;
      run <= '0;
    end else if (sync[1] == lvl) begin
      run <= '0;
    end else if (RUNW'(run + 1'b1) >= need) begin
      lvl <= sync[1];
      run <= '0;
    end else begin
      run <= RUNW'(run + 1'b1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;

  assign hit = edge_neg ? (lvl_q & ~lvl) : (lvl & ~lvl_q);

  always_comb
    case (div_cfg)
      2'd0:    lim = 3'd0;
      2'd1:    lim = 3'd1;
      2'd2:    lim = 3'd3;
      default: lim = 3'd7;
    endcase

  assign div_hit = hit && (evc == lim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        evc <= '0;
    else if (!chan_en) evc <= '0;
    else if (hit)      evc <= div_hit ? 3'd0 : evc + 3'd1;

  assign fire = chan_en & (div_hit | sw_trig);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_val  <= '0;
      cap_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (fire) cap_val <= cnt_in;
      cap_flag <= fire | (cap_flag & ~rd_cap);
      ovr_flag <= (fire & cap_flag) | (ovr_flag & ~ovr_clr);
    end

  assign irq_req = cap_flag & irq_en;
  assign dma_req = cap_flag & dma_en;
endmodule

// File: rtl/cap_channel_chk.sv
module cap_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_en,
  input logic          rd_cap,
  input logic          fire,
  input logic [CW-1:0] cnt_in,
  input logic [CW-1:0] cap_val,
  input logic          cap_flag,
  input logic          ovr_flag,
  input logic          irq_req,
  input logic          dma_req
);
  // R1
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cap_flag && cap_val == $past(cnt_in));

  // R2
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cap_flag |=> ovr_flag);

  // R2
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(cap_flag));

  // R7
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> $stable(cap_val));

  // R9
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap && !fire |=> !cap_flag);

  // R10
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_flag |-> !irq_req && !dma_req);
endmodule

bind cap_channel cap_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .rd_cap(rd_cap),
  .fire(fire), .cnt_in(cnt_in), .cap_val(cap_val), .cap_flag(cap_flag),
  .ovr_flag(ovr_flag), .irq_req(irq_req), .dma_req(dma_req)
);

// File: tb/sim_cap_channel.sv
`timescale 1ns/1ps
module sim_cap_channel;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_own = 0, pin_alt = 0, src_sel = 0, edge_neg = 0;
  logic [3:0] flt_cfg = '0;
  logic [1:0] div_cfg = '0;
  logic chan_en = 0, sw_trig = 0, irq_en = 0, dma_en = 0, rd_cap = 0, ovr_clr = 0;
  logic [CW-1:0] cnt_in = '0;
  logic [CW-1:0] cap_val;
  logic cap_flag, ovr_flag, irq_req, dma_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  cap_channel #(.CW(CW)) u0 (.*);

  // [15] src_sel, [14] edge_neg, [13:10] flt_cfg, [9:8] div_cfg, [7:0] pulses
  localparam logic [15:0] VEC [6] = '{
    {1'b0, 1'b0, 4'd0,  2'd0, 8'd3},
    {1'b1, 1'b0, 4'd2,  2'd0, 8'd2},
    {1'b0, 1'b1, 4'd1,  2'd1, 8'd4},
    {1'b1, 1'b1, 4'd4,  2'd2, 8'd8},
    {1'b0, 1'b0, 4'd3,  2'd3, 8'd8},
    {1'b0, 1'b0, 4'd15, 2'd1, 8'd2}
  };

  task automatic done();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      done();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_pin(input logic v);
    if (src_sel) pin_alt = v; else pin_own = v;
  endtask

  task automatic pulse(input int w);
    drive_pin(1'b1);
    wait_n(w);
    drive_pin(1'b0);
  endtask

  task automatic do_read();
    rd_cap = 1'b1;
    wait_n(1);
    rd_cap = 1'b0;
    wait_n(1);
  endtask

  task automatic clear_all();
    rd_cap = 1'b1; ovr_clr = 1'b1;
    wait_n(1);
    rd_cap = 1'b0; ovr_clr = 1'b0;
    wait_n(1);
  endtask

  task automatic retoggle_en();
    chan_en = 1'b0;
    wait_n(2);
    chan_en = 1'b1;
    wait_n(1);
  endtask

  initial begin
    wait_n(3);
    // R11: reset state
    chk(cap_val == 0 && !cap_flag && !ovr_flag && !irq_req && !dma_req, "R11 reset",
        {cap_val, 3'b0, cap_flag, ovr_flag, irq_req, dma_req}, 0);
    rst_n = 1'b1;
    wait_n(2);

    // R1 R3 R4 R5 R6: vector table
    for (int v = 0; v < 6; v++) begin
      src_sel  = VEC[v][15];
      edge_neg = VEC[v][14];
      flt_cfg  = VEC[v][13:10];
      div_cfg  = VEC[v][9:8];
      wait_n(4);
      retoggle_en();
      clear_all();
      for (int p = 1; p <= int'(VEC[v][7:0]); p++) begin
        logic exp_cap;
        logic [CW-1:0] val;
        val = CW'(16'h100 * (v + 1) + p);
        exp_cap = (p % (1 << VEC[v][9:8])) == 0;
        cnt_in = val;
        drive_pin(1'b1);
        wait_n(40);
        // R3: rising edge captures before the fall, falling edge only after it
        chk(cap_flag == (exp_cap && !edge_neg), "R3 polarity mid-pulse", cap_flag, exp_cap && !edge_neg);
        drive_pin(1'b0);
        wait_n(40);
        // R1 R4 R6: capture on the selected pin, every 2^div edges
        chk(cap_flag == exp_cap, "R6 divider/R4 source flag", cap_flag, exp_cap);
        if (exp_cap) chk(cap_val == val, "R1 captured value", cap_val, val);
        if (cap_flag) do_read();
      end
    end

    // R5: filter rejects a short pulse, accepts a long enough one
    src_sel = 0; edge_neg = 0; div_cfg = 0; flt_cfg = 4'd3;
    retoggle_en(); clear_all();
    cnt_in = 16'h0AAA;
    pulse(5);
    wait_n(40);
    chk(!cap_flag, "R5 short pulse rejected (N=8)", cap_flag, 0);
    cnt_in = 16'h0BBB;
    pulse(12);
    wait_n(40);
    chk(cap_flag && cap_val == 16'h0BBB, "R5 long pulse accepted (N=8)", cap_val, 16'h0BBB);
    do_read();
    flt_cfg = 4'd0;
    cnt_in = 16'h0CCC;
    pulse(1);
    wait_n(20);
    chk(cap_flag && cap_val == 16'h0CCC, "R5 one-sample pulse with no filter", cap_val, 16'h0CCC);
    do_read();
    // R4: unselected pin ignored
    pin_alt = 1'b1; wait_n(20); pin_alt = 1'b0; wait_n(20);
    chk(!cap_flag, "R4 unselected pin ignored", cap_flag, 0);

    // R2 R9: overcapture, then clears
    cnt_in = 16'h1111; pulse(10); wait_n(30);
    cnt_in = 16'h2222; pulse(10); wait_n(30);
    chk(ovr_flag, "R2 overcapture flag", ovr_flag, 1);
    chk(cap_val == 16'h2222, "R2 register overwritten", cap_val, 16'h2222);
    do_read();
    chk(!cap_flag && ovr_flag, "R9 read clears only capture flag", {cap_flag, ovr_flag}, 2'b01);
    ovr_clr = 1'b1; wait_n(1); ovr_clr = 1'b0; wait_n(1);
    chk(!ovr_flag, "R9 overcapture clear", ovr_flag, 0);
    // R9: capture wins over read in the same cycle
    cnt_in = 16'h3333;
    sw_trig = 1'b1; rd_cap = 1'b1; wait_n(1);
    sw_trig = 1'b0; rd_cap = 1'b0; wait_n(1);
    chk(cap_flag && cap_val == 16'h3333, "R9 capture beats read", cap_flag, 1);
    do_read();

    // R8: software trigger ignores divider
    div_cfg = 2'd3; retoggle_en();
    cnt_in = 16'h4444;
    sw_trig = 1'b1; wait_n(1); sw_trig = 1'b0; wait_n(1);
    chk(cap_flag && cap_val == 16'h4444, "R8 software trigger", cap_val, 16'h4444);

    // R10: request outputs
    irq_en = 1'b1; dma_en = 1'b0; wait_n(1);
    chk(irq_req && !dma_req, "R10 irq only", {irq_req, dma_req}, 2'b10);
    irq_en = 1'b0; dma_en = 1'b1; wait_n(1);
    chk(!irq_req && dma_req, "R10 dma only", {irq_req, dma_req}, 2'b01);
    do_read();
    irq_en = 1'b1;
    chk(!irq_req && !dma_req, "R10 no request without flag", {irq_req, dma_req}, 2'b00);
    irq_en = 1'b0; dma_en = 1'b0;

    // R7: disabled channel ignores pin and software trigger
    div_cfg = 2'd0; chan_en = 1'b0;
    cnt_in = 16'h5555;
    pulse(10); wait_n(30);
    sw_trig = 1'b1; wait_n(1); sw_trig = 1'b0; wait_n(2);
    chk(!cap_flag && cap_val == 16'h4444, "R7 disabled channel", cap_val, 16'h4444);

    // R6: edge count restarts after disable
    div_cfg = 2'd1; chan_en = 1'b1; wait_n(2);
    cnt_in = 16'h6666; pulse(10); wait_n(30);
    chk(!cap_flag, "R6 first of two edges", cap_flag, 0);
    retoggle_en();
    cnt_in = 16'h7777; pulse(10); wait_n(30);
    chk(!cap_flag, "R6 count cleared by disable", cap_flag, 0);
    cnt_in = 16'h8888; pulse(10); wait_n(30);
    chk(cap_flag && cap_val == 16'h8888, "R6 second edge after restart", cap_val, 16'h8888);

    done();
  end
endmodule